// File: doc/BRIEF.md
# Byte-Port Frame Buffer Network Interface

This block is a small host-visible network interface. It holds one receive frame and one transmit frame in two byte-wide buffers. A 32-bit register bus gives the host identification words, a busy indicator, a count register for each direction, an interrupt-control register and an interrupt-information word. The host moves frame data one byte per bus access through two data ports: it pushes bytes into the transmit port and pops bytes from the receive port.

Frames arrive on a byte stream with valid and last markers. They are written into the receive buffer and committed when the last byte arrives. A frame is dropped if it reaches the buffer size. The host programs a transmit length and then pushes bytes. When the written count meets that length, or the buffer fills, the frame leaves on an outgoing byte stream as back-to-back beats, and the transmit pointer and count return to zero. One level interrupt line reports the OR of three flags: transmit-done, receive-done and a host-settable test flag.

Top module: `mmio_frame_nic`

## Requirements
- R1: A read at offset 0x00 returns 0x4D495053 and a read at offset 0x04 returns 0x4E455430.
- R2: After reset, busy (0x08), receive count (0x0C), transmit count (0x10) and interrupt control (0x14) all read 0, irq is low and tx_valid is low.
- R3: A write to 0x10 stores the value when it is at most FRAME_BYTES and stores 0 otherwise. Reads of 0x10 return the stored value.
- R4: Each write to 0x20 stores wdata[7:0] at the write pointer and advances the pointer. When the advanced pointer equals the stored count, or reaches FRAME_BYTES, the frame is emitted starting in the next cycle: one beat per cycle in write order, tx_last on the final beat, with no gaps. In the same edge the pointer and the count register return to 0.
- R5: Interrupt-control bit 0 (transmit-done) is set in the cycle after the final beat. Writes to 0x20 while a frame is being emitted are ignored.
- R6: irq is high exactly while any of bit 0 (transmit-done), bit 1 (receive-done) or bit 31 (test) of interrupt control is set.
- R7: A write to 0x14 acts on a single bit, in priority order: wdata bit 0 clears transmit-done; otherwise bit 1 clears receive-done; otherwise bit 31 sets test. A hardware set of a flag in the same cycle wins over the clear.
- R8: After a write to 0x14, busy (0x08, bit 0) equals whether any flag is set. Busy changes at no other time.
- R9: A read of 0x14 returns the flags as they were and then clears the test flag.
- R10: A received frame shorter than FRAME_BYTES bytes sets the receive count to its length, rewinds the read pointer and sets receive-done, replacing any unread frame. A frame of FRAME_BYTES bytes or more is dropped, leaving count and flags untouched.
- R11: A read of 0x1C returns the byte at the read pointer in bits 7:0, advances the pointer and decrements the count. When the count is 0 the read returns 0 and changes nothing.
- R12: Writes to 0x0C, 0x18 and 0x1C are ignored. Reads of 0x18 return INFO_VALUE and reads of 0x20 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| rx_byte | input | 8 | Incoming frame byte |
| rx_valid | input | 1 | rx_byte carries a byte this cycle |
| rx_last | input | 1 | This byte ends the incoming frame |
| tx_byte | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_byte carries a byte this cycle |
| tx_last | output | 1 | This beat ends the outgoing frame |
| irq | output | 1 | Level interrupt, OR of the interrupt-control flags |

## Verification
The bench builds the block with FRAME_BYTES set to 16 and INFO_VALUE set to 5. The small buffer lets the bench reach the size limits in a few dozen cycles. Those cases are a 15-byte frame accepted as the largest legal one, 16- and 20-byte frames dropped, a transmit launch forced by a full buffer with no count programmed, and a count write of 17 clamped to 0. The non-zero information word shows that the parameter reaches the register read path.

// File: rtl/nic_pkg.sv
package nic_pkg;

    // Register offsets (byte addresses on the host bus)
    localparam logic [5:0] OFS_ID_HI    = 6'h00;
    localparam logic [5:0] OFS_ID_LO    = 6'h04;
    localparam logic [5:0] OFS_BUSY     = 6'h08;
    localparam logic [5:0] OFS_RX_CNT   = 6'h0C;
    localparam logic [5:0] OFS_TX_CNT   = 6'h10;
    localparam logic [5:0] OFS_IRQ_CTL  = 6'h14;
    localparam logic [5:0] OFS_IRQ_INFO = 6'h18;
    localparam logic [5:0] OFS_RX_PORT  = 6'h1C;
    localparam logic [5:0] OFS_TX_PORT  = 6'h20;

    localparam logic [31:0] ID_WORD_HI = 32'h4D49_5053;
    localparam logic [31:0] ID_WORD_LO = 32'h4E45_5430;

    // Internal flag vector positions
    localparam int FLAG_TX   = 0;
    localparam int FLAG_RX   = 1;
    localparam int FLAG_TEST = 2;
    localparam int FLAG_N    = 3;

    // Register bit positions of the flags in the interrupt-control word
    localparam int CTL_BIT_TX   = 0;
    localparam int CTL_BIT_RX   = 1;
    localparam int CTL_BIT_TEST = 31;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_DROP = 2'd2
    } rx_mode_e;

endpackage

// File: rtl/nic_byte_ram.sv
module nic_byte_ram #(
    parameter int DEPTH = 1514,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/nic_rx_path.sv
module nic_rx_path
    import nic_pkg::*;
#(
    parameter int FRAME_BYTES = 1514,
    parameter int PTR_W       = 11,
    parameter int IDX_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       rx_byte,
    input  logic             rx_valid,
    input  logic             rx_last,
    input  logic             pop,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_widx,
    output logic [7:0]       ram_wbyte,
    output logic [IDX_W-1:0] ram_ridx,
    output logic [PTR_W-1:0] count,
    output logic             commit
);

    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(FRAME_BYTES);

    typedef struct packed {
        rx_mode_e         mode;
        logic [PTR_W-1:0] fill;
        logic [PTR_W-1:0] count;
        logic [PTR_W-1:0] rd_ptr;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [PTR_W-1:0] fill_base;
    logic [PTR_W-1:0] fill_next;
    logic             has_room;

    always_comb begin
        st_d      = st_q;
        commit    = 1'b0;
        ram_we    = 1'b0;
        fill_base = (st_q.mode == RX_FILL) ? st_q.fill : '0;
        fill_next = fill_base + 1'b1;
        has_room  = (st_q.count < LIMIT);

        // host pop through the data port
        if (pop && (st_q.count != '0)) begin
            st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            st_d.count  = st_q.count - 1'b1;
        end

        // incoming stream
        if (rx_valid) begin
            unique case (st_q.mode)
                RX_DROP: begin
                    if (rx_last) st_d.mode = RX_IDLE;
                end
                default: begin
                    if ((st_q.mode == RX_IDLE) && !has_room) begin
                        st_d.mode = rx_last ? RX_IDLE : RX_DROP;
                    end else begin
                        ram_we = 1'b1;
                        if (fill_next >= LIMIT) begin
                            st_d.mode = rx_last ? RX_IDLE : RX_DROP;
                        end else if (rx_last) begin
                            st_d.mode   = RX_IDLE;
                            st_d.count  = fill_next;
                            st_d.rd_ptr = '0;
                            commit      = 1'b1;
                        end else begin
                            st_d.mode = RX_FILL;
                            st_d.fill = fill_next;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: RX_IDLE, fill: '0, count: '0, rd_ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_widx  = fill_base[IDX_W-1:0];
    assign ram_wbyte = rx_byte;
    assign ram_ridx  = st_q.rd_ptr[IDX_W-1:0];
    assign count     = st_q.count;

endmodule

// File: rtl/nic_tx_path.sv
module nic_tx_path #(
    parameter int FRAME_BYTES = 1514,
    parameter int PTR_W       = 11,
    parameter int IDX_W       = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_we,
    input  logic [31:0]      len_val,
    input  logic             byte_we,
    input  logic [7:0]       byte_val,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_widx,
    output logic [7:0]       ram_wbyte,
    output logic [IDX_W-1:0] ram_ridx,
    output logic [PTR_W-1:0] len,
    output logic             tx_valid,
    output logic             tx_last,
    output logic             done
);

    localparam logic [PTR_W-1:0] LIMIT = PTR_W'(FRAME_BYTES);

    typedef struct packed {
        logic [PTR_W-1:0] len;
        logic [PTR_W-1:0] wr_ptr;
        logic             sending;
        logic [PTR_W-1:0] send_len;
        logic [PTR_W-1:0] send_idx;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [PTR_W-1:0] wr_next;
    logic             final_beat;

    assign final_beat = st_q.sending && (st_q.send_idx == (st_q.send_len - 1'b1));

    always_comb begin
        st_d    = st_q;
        done    = 1'b0;
        ram_we  = 1'b0;
        wr_next = st_q.wr_ptr + 1'b1;

        if (len_we) begin
            st_d.len = (len_val <= 32'(FRAME_BYTES)) ? len_val[PTR_W-1:0] : '0;
        end

        if (st_q.sending) begin
            if (final_beat) begin
                st_d.sending  = 1'b0;
                st_d.send_idx = '0;
                done          = 1'b1;
            end else begin
                st_d.send_idx = st_q.send_idx + 1'b1;
            end
        end else if (byte_we) begin
            ram_we = 1'b1;
            if ((wr_next >= LIMIT) || (wr_next == st_q.len)) begin
                st_d.sending  = 1'b1;
                st_d.send_len = wr_next;
                st_d.send_idx = '0;
                st_d.wr_ptr   = '0;
                st_d.len      = '0;
            end else begin
                st_d.wr_ptr = wr_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{len: '0, wr_ptr: '0, sending: 1'b0, send_len: '0, send_idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_widx  = st_q.wr_ptr[IDX_W-1:0];
    assign ram_wbyte = byte_val;
    assign ram_ridx  = st_q.send_idx[IDX_W-1:0];
    assign len       = st_q.len;
    assign tx_valid  = st_q.sending;
    assign tx_last   = final_beat;

endmodule

// File: rtl/mmio_frame_nic.sv
module mmio_frame_nic
    import nic_pkg::*;
#(
    parameter int          FRAME_BYTES = 1514,
    parameter logic [31:0] INFO_VALUE  = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    input  logic        rx_last,
    output logic [7:0]  tx_byte,
    output logic        tx_valid,
    output logic        tx_last,
    output logic        irq
);

    localparam int PTR_W = $clog2(FRAME_BYTES + 1);
    localparam int IDX_W = $clog2(FRAME_BYTES);

    typedef struct packed {
        logic [FLAG_N-1:0] flags;
        logic              busy;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic bus_rd, bus_wr;
    assign bus_rd = bus_en && !bus_we;
    assign bus_wr = bus_en && bus_we;

    // receive side
    logic             rx_we;
    logic [IDX_W-1:0] rx_widx, rx_ridx;
    logic [7:0]       rx_wbyte, rx_rbyte;
    logic [PTR_W-1:0] rx_cnt;
    logic             rx_commit;

    nic_rx_path #(.FRAME_BYTES(FRAME_BYTES), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_last  (rx_last),
        .pop      (bus_rd && (bus_addr == OFS_RX_PORT)),
        .ram_we   (rx_we),
        .ram_widx (rx_widx),
        .ram_wbyte(rx_wbyte),
        .ram_ridx (rx_ridx),
        .count    (rx_cnt),
        .commit   (rx_commit)
    );

    nic_byte_ram #(.DEPTH(FRAME_BYTES), .AW(IDX_W)) u_rx_ram (
        .clk    (clk),
        .wr_en  (rx_we),
        .wr_addr(rx_widx),
        .wr_data(rx_wbyte),
        .rd_addr(rx_ridx),
        .rd_data(rx_rbyte)
    );

    // transmit side
    logic             tx_we;
    logic [IDX_W-1:0] tx_widx, tx_ridx;
    logic [7:0]       tx_wbyte;
    logic [PTR_W-1:0] tx_len;
    logic             tx_done;

    nic_tx_path #(.FRAME_BYTES(FRAME_BYTES), .PTR_W(PTR_W), .IDX_W(IDX_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .len_we   (bus_wr && (bus_addr == OFS_TX_CNT)),
        .len_val  (bus_wdata),
        .byte_we  (bus_wr && (bus_addr == OFS_TX_PORT)),
        .byte_val (bus_wdata[7:0]),
        .ram_we   (tx_we),
        .ram_widx (tx_widx),
        .ram_wbyte(tx_wbyte),
        .ram_ridx (tx_ridx),
        .len      (tx_len),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .done     (tx_done)
    );

    nic_byte_ram #(.DEPTH(FRAME_BYTES), .AW(IDX_W)) u_tx_ram (
        .clk    (clk),
        .wr_en  (tx_we),
        .wr_addr(tx_widx),
        .wr_data(tx_wbyte),
        .rd_addr(tx_ridx),
        .rd_data(tx_byte)
    );

    // interrupt flags and busy
    always_comb begin
        st_d = st_q;

        if (bus_rd && (bus_addr == OFS_IRQ_CTL)) begin
            st_d.flags[FLAG_TEST] = 1'b0;
        end

        if (bus_wr && (bus_addr == OFS_IRQ_CTL)) begin
            if (bus_wdata[CTL_BIT_TX]) begin
                st_d.flags[FLAG_TX] = 1'b0;
            end else if (bus_wdata[CTL_BIT_RX]) begin
                st_d.flags[FLAG_RX] = 1'b0;
            end else if (bus_wdata[CTL_BIT_TEST]) begin
                st_d.flags[FLAG_TEST] = 1'b1;
            end
        end

        // hardware events take precedence over a same-cycle clear
        if (tx_done)   st_d.flags[FLAG_TX] = 1'b1;
        if (rx_commit) st_d.flags[FLAG_RX] = 1'b1;

        if (bus_wr && (bus_addr == OFS_IRQ_CTL)) begin
            st_d.busy = |st_d.flags;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flags: '0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // read data
    logic [31:0] ctl_word;
    always_comb begin
        ctl_word               = '0;
        ctl_word[CTL_BIT_TX]   = st_q.flags[FLAG_TX];
        ctl_word[CTL_BIT_RX]   = st_q.flags[FLAG_RX];
        ctl_word[CTL_BIT_TEST] = st_q.flags[FLAG_TEST];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_ID_HI:    bus_rdata = ID_WORD_HI;
                OFS_ID_LO:    bus_rdata = ID_WORD_LO;
                OFS_BUSY:     bus_rdata = {31'd0, st_q.busy};
                OFS_RX_CNT:   bus_rdata = 32'(rx_cnt);
                OFS_TX_CNT:   bus_rdata = 32'(tx_len);
                OFS_IRQ_CTL:  bus_rdata = ctl_word;
                OFS_IRQ_INFO: bus_rdata = INFO_VALUE;
                OFS_RX_PORT:  bus_rdata = (rx_cnt != '0) ? {24'd0, rx_rbyte} : 32'd0;
                default:      bus_rdata = '0;
            endcase
        end
    end

    logic [FLAG_N-1:0] irq_flags;
    assign irq_flags = st_q.flags;
    assign irq       = |st_q.flags;

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int FRAME_BYTES = 1514,
    localparam int PTR_W = $clog2(FRAME_BYTES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_we,
    input logic [5:0]       bus_addr,
    input logic             rx_valid,
    input logic             tx_valid,
    input logic             tx_last,
    input logic             irq,
    input logic [2:0]       irq_flags,
    input logic [PTR_W-1:0] rx_cnt,
    input logic [PTR_W-1:0] tx_len
);

    // R10: a committed frame is always shorter than the buffer
    assert_rx_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) < FRAME_BYTES);

    // R3: the stored transmit count never exceeds the buffer
    assert_tx_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_len) <= FRAME_BYTES);

    // R4: the end marker only appears on a live beat
    assert_last_on_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

    // R4: beats are back to back until the end marker
    assert_beats_contiguous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_last) |=> tx_valid);

    // R7: the interrupt only drops after an access to interrupt control
    assert_irq_drop_needs_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_en && (bus_addr == 6'h14)));

    // R9: reading interrupt control clears the test flag
    assert_test_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && (bus_addr == 6'h14)) |=> !irq_flags[2]);

    // R12: a write to the receive count leaves it alone
    assert_ro_rx_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && (bus_addr == 6'h0C) && !rx_valid) |=> $stable(rx_cnt));

endmodule

bind mmio_frame_nic nic_checker #(.FRAME_BYTES(FRAME_BYTES)) u_nic_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .rx_valid (rx_valid),
    .tx_valid (tx_valid),
    .tx_last  (tx_last),
    .irq      (irq),
    .irq_flags(irq_flags),
    .rx_cnt   (rx_cnt),
    .tx_len   (tx_len)
);

// File: tb/mmio_frame_nic_test.sv
`timescale 1ns/100ps
module mmio_frame_nic_test;

    localparam int          FB   = 16;
    localparam logic [31:0] INFO = 32'h5;

    localparam logic [5:0] A_IDH = 6'h00, A_IDL = 6'h04, A_BUSY = 6'h08, A_RXC = 6'h0C,
                           A_TXC = 6'h10, A_CTL = 6'h14, A_INFO = 6'h18, A_RXP = 6'h1C,
                           A_TXP = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid, tx_last, irq;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mmio_frame_nic #(.FRAME_BYTES(FB), .INFO_VALUE(INFO)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_last(rx_last), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_last(tx_last), .irq(irq)
    );

    // ---------------- reference model ----------------
    bit [2:0]   m_flags;   // 0 tx-done, 1 rx-done, 2 test
    bit         m_busy;
    int         m_txcnt;
    int         m_rxmode;  // 0 idle, 1 filling, 2 dropping
    logic [7:0] m_txq[$];
    logic [7:0] m_sendq[$];
    logic [7:0] m_rxq[$];
    logic [7:0] m_fillq[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = '0; m_busy = 1'b0; m_txcnt = 0; m_rxmode = 0;
            m_txq.delete(); m_sendq.delete(); m_rxq.delete(); m_fillq.delete();
        end else begin
            bit set_tx, set_rx, was_sending;
            set_tx = 1'b0; set_rx = 1'b0;
            was_sending = (m_sendq.size() > 0);
            if (was_sending) begin
                void'(m_sendq.pop_front());
                if (m_sendq.size() == 0) set_tx = 1'b1;
            end
            if (bus_en && bus_we && bus_addr == A_TXC)
                m_txcnt = (bus_wdata <= 32'(FB)) ? int'(bus_wdata) : 0;
            if (bus_en && bus_we && bus_addr == A_TXP && !was_sending) begin
                m_txq.push_back(bus_wdata[7:0]);
                if (m_txq.size() == m_txcnt || m_txq.size() >= FB) begin
                    m_sendq = m_txq;
                    m_txq.delete();
                    m_txcnt = 0;
                end
            end
            if (bus_en && !bus_we && bus_addr == A_CTL) m_flags[2] = 1'b0;
            if (bus_en && bus_we && bus_addr == A_CTL) begin
                if (bus_wdata[0])       m_flags[0] = 1'b0;
                else if (bus_wdata[1])  m_flags[1] = 1'b0;
                else if (bus_wdata[31]) m_flags[2] = 1'b1;
            end
            if (bus_en && !bus_we && bus_addr == A_RXP && m_rxq.size() > 0)
                void'(m_rxq.pop_front());
            if (rx_valid) begin
                if (m_rxmode == 2) begin
                    if (rx_last) m_rxmode = 0;
                end else begin
                    if (m_rxmode == 0) m_fillq.delete();
                    m_fillq.push_back(rx_byte);
                    if (m_fillq.size() >= FB) m_rxmode = rx_last ? 0 : 2;
                    else if (rx_last) begin
                        m_rxq = m_fillq; m_rxmode = 0; set_rx = 1'b1;
                    end else m_rxmode = 1;
                end
            end
            if (set_tx) m_flags[0] = 1'b1;
            if (set_rx) m_flags[1] = 1'b1;
            if (bus_en && bus_we && bus_addr == A_CTL) m_busy = |m_flags;
        end
    end

    function automatic logic [31:0] model_read(logic [5:0] a);
        case (a)
            A_IDH:  return 32'h4D495053;
            A_IDL:  return 32'h4E455430;
            A_BUSY: return {31'd0, m_busy};
            A_RXC:  return 32'(m_rxq.size());
            A_TXC:  return 32'(m_txcnt);
            A_CTL:  return {m_flags[2], 29'd0, m_flags[1], m_flags[0]};
            A_INFO: return INFO;
            A_RXP:  return (m_rxq.size() > 0) ? {24'd0, m_rxq[0]} : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison of the outputs against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            chk("R6 irq", {31'd0, irq}, {31'd0, |m_flags});
            chk("R4 tx_valid", {31'd0, tx_valid}, {31'd0, m_sendq.size() > 0});
            chk("R4 tx_last", {31'd0, tx_last}, {31'd0, m_sendq.size() == 1});
            if (m_sendq.size() > 0) chk("R4 tx_byte", {24'd0, tx_byte}, {24'd0, m_sendq[0]});
        end
    end

    // ---------------- stimulus tasks (called just after a falling edge) ----------------
    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(string req, logic [5:0] a);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, model_read(a));
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_lit(string req, logic [5:0] a, logic [31:0] exp);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rx_frame(int n, logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_byte = seed + 8'(i); rx_last = (i == n - 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic tx_bytes(int n, logic [7:0] seed);
        for (int i = 0; i < n; i++) wr(A_TXP, {24'd0, seed + 8'(i * 3)});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset state
        rd_lit("R2 busy", A_BUSY, 32'd0);
        rd_lit("R2 rx count", A_RXC, 32'd0);
        rd_lit("R2 tx count", A_TXC, 32'd0);
        rd_lit("R2 irq ctl", A_CTL, 32'd0);
        chk("R2 irq pin", {31'd0, irq}, 32'd0);
        chk("R2 tx_valid", {31'd0, tx_valid}, 32'd0);

        // R1 identification
        rd_lit("R1 id hi", A_IDH, 32'h4D495053);
        rd_lit("R1 id lo", A_IDL, 32'h4E455430);

        // R12 read-only registers and fixed reads
        rd_lit("R12 info", A_INFO, INFO);
        rd_lit("R12 tx port read", A_TXP, 32'd0);
        wr(A_RXC, 32'd7);
        wr(A_INFO, 32'hFF);
        wr(A_RXP, 32'h3C);
        rd_lit("R12 rx count kept", A_RXC, 32'd0);
        rd_lit("R12 info kept", A_INFO, INFO);
        rd_lit("R12 rx port empty", A_RXP, 32'd0);

        // R3 count clamp
        wr(A_TXC, 32'd17);
        rd_lit("R3 oversize -> 0", A_TXC, 32'd0);
        wr(A_TXC, 32'd16);
        rd_lit("R3 max kept", A_TXC, 32'd16);
        wr(A_TXC, 32'hFFFF_FFF0);
        rd_lit("R3 huge -> 0", A_TXC, 32'd0);

        // R4 / R5 frame of 5 bytes
        wr(A_TXC, 32'd5);
        tx_bytes(4, 8'h10);
        rd_lit("R4 count held mid-frame", A_TXC, 32'd5);
        tx_bytes(1, 8'h40);
        rd_lit("R4 count cleared on launch", A_TXC, 32'd0);
        idle(8);
        rd_lit("R5 tx-done flag", A_CTL, 32'h1);

        // R5 writes during emission ignored
        wr(A_TXC, 32'd3);
        tx_bytes(3, 8'h80);
        tx_bytes(2, 8'hE0);
        idle(4);
        wr(A_TXC, 32'd2);
        tx_bytes(2, 8'h21);
        idle(5);
        rd("R5 after ignored writes", A_TXC);

        // R4 launch by full buffer with no count programmed
        tx_bytes(FB, 8'h01);
        idle(FB + 3);

        // R10 receive a frame, then R7 priority
        rx_frame(4, 8'hA0);
        idle(1);
        rd_lit("R10 rx count", A_RXC, 32'd4);
        rd_lit("R7 both flags", A_CTL, 32'h3);
        wr(A_CTL, 32'h3);
        rd_lit("R7 bit0 first", A_CTL, 32'h2);
        rd_lit("R8 busy after write", A_BUSY, 32'd1);
        wr(A_CTL, 32'h8000_0002);
        rd_lit("R7 bit1 before bit31", A_CTL, 32'h0);
        rd_lit("R8 busy cleared", A_BUSY, 32'd0);
        wr(A_CTL, 32'h8000_0000);
        rd_lit("R8 busy test", A_BUSY, 32'd1);
        rd_lit("R9 test seen", A_CTL, 32'h8000_0000);
        rd_lit("R9 test cleared", A_CTL, 32'h0);
        rd_lit("R8 busy unchanged by read", A_BUSY, 32'd1);
        wr(A_CTL, 32'h0);
        rd_lit("R8 busy after empty write", A_BUSY, 32'd0);

        // R7 hardware set wins over same-cycle clear (1-byte frame, final beat next cycle)
        wr(A_TXC, 32'd1);
        wr(A_TXP, 32'h5A);
        wr(A_CTL, 32'h1);
        rd_lit("R7 set wins", A_CTL, 32'h1);
        wr(A_CTL, 32'h1);

        // R11 pop bytes
        rd_lit("R11 byte0", A_RXP, 32'hA0);
        rd_lit("R11 byte1", A_RXP, 32'hA1);
        rd_lit("R11 count", A_RXC, 32'd2);

        // R10 replacement of an unread frame
        rx_frame(3, 8'h30);
        idle(1);
        rd_lit("R10 replaced count", A_RXC, 32'd3);
        for (int i = 0; i < 3; i++) rd("R11 new frame byte", A_RXP);
        rd_lit("R11 empty read", A_RXP, 32'd0);
        rd_lit("R11 count stays 0", A_RXC, 32'd0);
        wr(A_CTL, 32'h2);

        // R10 drops at the size limit
        rx_frame(FB, 8'h50);
        idle(1);
        rd_lit("R10 drop exact", A_RXC, 32'd0);
        rx_frame(FB + 4, 8'h60);
        idle(1);
        rd_lit("R10 drop long", A_RXC, 32'd0);
        rd_lit("R10 no flag on drop", A_CTL, 32'h0);
        rx_frame(FB - 1, 8'hC0);
        idle(1);
        rd_lit("R10 largest accepted", A_RXC, 32'(FB - 1));
        for (int i = 0; i < FB - 1; i++) rd("R11 long frame byte", A_RXP);
        rx_frame(1, 8'h99);
        idle(1);
        rd_lit("R10 single byte", A_RXP, 32'h99);
        rd_lit("R11 drained", A_RXC, 32'd0);

        // R4 launch at count equal to buffer size
        wr(A_TXC, 32'd16);
        tx_bytes(FB, 8'h07);
        idle(FB + 3);
        rd("R5 final flags", A_CTL);

        idle(2);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule